// File: doc/BRIEF.md
# FIFO Ready-Pin Controller

This block keeps one byte queue for received data and one for data waiting to be sent, each up to 128 bytes deep. It drives two active-low pins, `rx_rdy_n` and `tx_rdy_n`, which an external block-move engine watches to decide when to drain the receive side or refill the transmit side. The block also reports each queue's fill count and its empty and full flags.

An 8-bit configuration word picks the pin rules. Bit 0 turns the deep queues on. With bit 0 clear, each side holds a single byte. With bit 0 set, bit 3 picks between per-byte signalling and burst signalling. In burst mode the receive pin has hysteresis: it asserts once the fill count reaches a programmable threshold, or when a timeout pulse arrives, and it releases only when the queue is drained to empty. A clear strobe for each side discards that side's contents.

Top module: `fifo_ready_ctrl`

## Requirements
- R1: Each queue holds at most 128 bytes when bit 0 of `cfg_word` is 1. `*_full` is 1 when the count equals the capacity. A push to a full queue, without a pop in the same cycle, leaves the count and the contents unchanged.
- R2: A pop from an empty queue leaves the count at 0 and leaves the data output holding the last byte popped. A pop that is accepted presents the oldest byte on the data output after the clock edge.
- R3: A push and a pop in the same cycle on a non-empty queue leave its count unchanged.
- R4: When bit 0 of `cfg_word` is 0, each queue's capacity is one byte and bit 3 is ignored. `rx_rdy_n` is 0 while a received byte is held and 1 otherwise. `tx_rdy_n` is 0 while the transmit side is empty and 1 while it holds a byte.
- R5: When bit 0 is 1 and bit 3 is 0, `rx_rdy_n` is 0 exactly when the receive count is at least 1. `tx_rdy_n` is 0 only while the transmit count is 0.
- R6: When bit 0 and bit 3 are both 1 and the receive queue is non-empty, `rx_rdy_n` goes to 0 when the receive count is at least `rx_trig` (1 to 128) or when `rx_timeout` is 1.
- R7: In that burst mode, `rx_rdy_n` goes to 1 when the receive count is 0. Otherwise it keeps its previous value.
- R8: In that burst mode, `tx_rdy_n` is 1 when the transmit queue is full and 0 when it has at least one free slot.
- R9: Both pins are registered. Each reflects the queue state and inputs of the cycle before the clock edge that updates it, so a pin changes one clock after the count that causes the change.
- R10: While `rst` is high, both pins are 1, both counts are 0, and both empty flags are 1.
- R11: A clear strobe empties its queue at the next edge, ahead of any push or pop in the same cycle. The pins reach their empty-queue levels one edge after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_word | input | 8 | Configuration word; bit 0 turns the deep queues on, bit 3 selects burst signalling |
| rx_trig | input | 8 | Receive threshold for burst mode, 1 to 128 |
| rx_timeout | input | 1 | Receive timeout pulse |
| rx_clr | input | 1 | Clear the receive queue |
| rx_push | input | 1 | Write `rx_din` into the receive queue |
| rx_din | input | 8 | Received byte |
| rx_pop | input | 1 | Read the oldest received byte |
| rx_dout | output | 8 | Last byte read from the receive queue |
| tx_clr | input | 1 | Clear the transmit queue |
| tx_push | input | 1 | Write `tx_din` into the transmit queue |
| tx_din | input | 8 | Byte to send |
| tx_pop | input | 1 | Read the oldest byte to send |
| tx_dout | output | 8 | Last byte read from the transmit queue |
| rx_count | output | 8 | Receive fill count |
| rx_empty | output | 1 | Receive queue empty |
| rx_full | output | 1 | Receive queue at capacity |
| tx_count | output | 8 | Transmit fill count |
| tx_empty | output | 1 | Transmit queue empty |
| tx_full | output | 1 | Transmit queue at capacity |
| rx_rdy_n | output | 1 | Active-low receive-ready pin |
| tx_rdy_n | output | 1 | Active-low transmit-ready pin |

## Verification
The assertions assume three things about the inputs: `rx_trig` stays within 1 to 128, the queue depth is a power of two, and all strobes are held stable across each clock edge. The overflow and stall properties only claim anything in cycles without a clear strobe. The stimulus keeps to these limits: it draws the threshold from 1 to 128 and changes every input on the falling edge. It runs push-heavy and pop-heavy phases so that both queues reach full and empty under every mode, with occasional timeouts and clears mixed in.

// File: rtl/fifo_rdy_pkg.sv
package fifo_rdy_pkg;
    localparam int DEF_DEPTH   = 128;
    localparam int DEF_DW      = 8;
    localparam int CFG_DEEP_BIT  = 0;
    localparam int CFG_BURST_BIT = 3;

    typedef enum logic [1:0] {
        MODE_SINGLE = 2'd0,
        MODE_STREAM = 2'd1,
        MODE_BURST  = 2'd2
    } pin_mode_e;

    function automatic pin_mode_e decode_mode(input logic deep, input logic burst);
        if (!deep)
            return MODE_SINGLE;
        else if (burst)
            return MODE_BURST;
        return MODE_STREAM;
    endfunction
endpackage

// File: rtl/rdy_fifo.sv
module rdy_fifo
    import fifo_rdy_pkg::*;
#(
    parameter int DW    = DEF_DW,
    parameter int DEPTH = DEF_DEPTH,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          deep,
    input  logic          push,
    input  logic [DW-1:0] din,
    input  logic          pop,
    output logic [DW-1:0] dout,
    output logic [CW-1:0] count,
    output logic          empty,
    output logic          full
);
    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] cap;
    logic          push_ok, pop_ok;

    assign cap     = deep ? CW'(DEPTH) : CW'(1);
    assign empty   = (count == '0);
    assign full    = (count >= cap);
    assign pop_ok  = pop && !empty && !clr;
    assign push_ok = push && !clr && (!full || pop_ok);

    always_ff @(posedge clk) begin
        if (push_ok)
            mem[wr_ptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
            dout   <= '0;
        end else if (clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok)
                wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + AW'(1);
            if (pop_ok) begin
                rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + AW'(1);
                dout   <= mem[rd_ptr];
            end
            case ({push_ok, pop_ok})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end

    // R1: never above the physical depth
    p_no_overflow_r1: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(DEPTH));
    // R1: push into a full queue is dropped
    p_full_push_r1: assert property (@(posedge clk) disable iff (rst)
        (full && push && !pop && !clr) |=> $stable(count));
    // R2: pop from empty changes nothing
    p_empty_pop_r2: assert property (@(posedge clk) disable iff (rst)
        (empty && pop && !push && !clr) |=> (empty && $stable(dout)));
    // R3: balanced push/pop
    p_balanced_r3: assert property (@(posedge clk) disable iff (rst)
        (!empty && push && pop && !clr) |=> $stable(count));
    // R11: clear empties the queue
    p_clear_r11: assert property (@(posedge clk) disable iff (rst)
        clr |=> empty);
endmodule

// File: rtl/rdy_pin_logic.sv
module rdy_pin_logic
    import fifo_rdy_pkg::*;
#(
    parameter int DEPTH = DEF_DEPTH,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  pin_mode_e     mode,
    input  logic [CW-1:0] rx_cnt,
    input  logic          rx_empty,
    input  logic [CW-1:0] rx_trig,
    input  logic          rx_tmo,
    input  logic          tx_empty,
    input  logic          tx_full,
    output logic          rx_rdy_n,
    output logic          tx_rdy_n
);
    logic rx_nx, tx_nx;

    always_comb begin
        rx_nx = rx_rdy_n;
        tx_nx = tx_rdy_n;
        case (mode)
            MODE_BURST: begin
                if (rx_empty)
                    rx_nx = 1'b1;
                else if ((rx_cnt >= rx_trig) || rx_tmo)
                    rx_nx = 1'b0;
                tx_nx = tx_full;
            end
            default: begin
                rx_nx = rx_empty;
                tx_nx = !tx_empty;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_rdy_n <= 1'b1;
            tx_rdy_n <= 1'b1;
        end else begin
            rx_rdy_n <= rx_nx;
            tx_rdy_n <= tx_nx;
        end
    end

    // R4 R5: per-byte signalling follows occupancy one clock later
    p_rx_follow_r5: assert property (@(posedge clk) disable iff (rst)
        (mode != MODE_BURST) |=> (rx_rdy_n == $past(rx_empty)));
    p_tx_follow_r4: assert property (@(posedge clk) disable iff (rst)
        (mode != MODE_BURST) |=> (tx_rdy_n == !$past(tx_empty)));
    // R6: threshold or timeout asserts the receive pin
    p_rx_assert_r6: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_BURST && !rx_empty && (rx_cnt >= rx_trig || rx_tmo)) |=> !rx_rdy_n);
    // R7: release only on empty, hold otherwise
    p_rx_release_r7: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_BURST && rx_empty) |=> rx_rdy_n);
    p_rx_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_BURST && !rx_empty && rx_cnt < rx_trig && !rx_tmo) |=> $stable(rx_rdy_n));
    // R8: transmit pin tracks full in burst mode
    p_tx_burst_r8: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_BURST) |=> (tx_rdy_n == $past(tx_full)));
endmodule

// File: rtl/fifo_ready_ctrl.sv
module fifo_ready_ctrl
    import fifo_rdy_pkg::*;
#(
    parameter int DW    = DEF_DW,
    parameter int DEPTH = DEF_DEPTH,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [7:0]    cfg_word,
    input  logic [CW-1:0] rx_trig,
    input  logic          rx_timeout,
    input  logic          rx_clr,
    input  logic          rx_push,
    input  logic [DW-1:0] rx_din,
    input  logic          rx_pop,
    output logic [DW-1:0] rx_dout,
    input  logic          tx_clr,
    input  logic          tx_push,
    input  logic [DW-1:0] tx_din,
    input  logic          tx_pop,
    output logic [DW-1:0] tx_dout,
    output logic [CW-1:0] rx_count,
    output logic          rx_empty,
    output logic          rx_full,
    output logic [CW-1:0] tx_count,
    output logic          tx_empty,
    output logic          tx_full,
    output logic          rx_rdy_n,
    output logic          tx_rdy_n
);
    pin_mode_e mode;
    logic      deep;
    logic      unused_cfg_bits;

    assign deep            = cfg_word[CFG_DEEP_BIT];
    assign mode            = decode_mode(deep, cfg_word[CFG_BURST_BIT]);
    assign unused_cfg_bits = ^{cfg_word[7:4], cfg_word[2:1]};

    rdy_fifo #(.DW(DW), .DEPTH(DEPTH)) rx_q_i (
        .clk(clk), .rst(rst), .clr(rx_clr), .deep(deep),
        .push(rx_push), .din(rx_din), .pop(rx_pop), .dout(rx_dout),
        .count(rx_count), .empty(rx_empty), .full(rx_full)
    );

    rdy_fifo #(.DW(DW), .DEPTH(DEPTH)) tx_q_i (
        .clk(clk), .rst(rst), .clr(tx_clr), .deep(deep),
        .push(tx_push), .din(tx_din), .pop(tx_pop), .dout(tx_dout),
        .count(tx_count), .empty(tx_empty), .full(tx_full)
    );

    rdy_pin_logic #(.DEPTH(DEPTH)) pins_i (
        .clk(clk), .rst(rst), .mode(mode),
        .rx_cnt(rx_count), .rx_empty(rx_empty), .rx_trig(rx_trig), .rx_tmo(rx_timeout),
        .tx_empty(tx_empty), .tx_full(tx_full),
        .rx_rdy_n(rx_rdy_n), .tx_rdy_n(tx_rdy_n)
    );

    // R10: reset values of the pins and flags
    p_reset_r10: assert property (@(posedge clk)
        $past(rst) |-> (rx_rdy_n && tx_rdy_n && rx_empty && tx_empty));
endmodule

// File: tb/fifo_ready_ctrl_tb_top.sv
module fifo_ready_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] cfg_word = 8'h01;
    logic [7:0] rx_trig = 8'd1;
    logic       rx_timeout = 1'b0, rx_clr = 1'b0, rx_push = 1'b0, rx_pop = 1'b0;
    logic       tx_clr = 1'b0, tx_push = 1'b0, tx_pop = 1'b0;
    logic [7:0] rx_din = 8'h00, tx_din = 8'h00;
    logic [7:0] rx_dout, tx_dout, rx_count, tx_count;
    logic       rx_empty, rx_full, tx_empty, tx_full, rx_rdy_n, tx_rdy_n;

    int errors = 0;
    int checks = 0;
    bit mon_on = 1'b0;

    always #2 clk = ~clk;

    fifo_ready_ctrl dut_i (
        .clk(clk), .rst(rst), .cfg_word(cfg_word), .rx_trig(rx_trig),
        .rx_timeout(rx_timeout), .rx_clr(rx_clr), .rx_push(rx_push), .rx_din(rx_din),
        .rx_pop(rx_pop), .rx_dout(rx_dout), .tx_clr(tx_clr), .tx_push(tx_push),
        .tx_din(tx_din), .tx_pop(tx_pop), .tx_dout(tx_dout), .rx_count(rx_count),
        .rx_empty(rx_empty), .rx_full(rx_full), .tx_count(tx_count), .tx_empty(tx_empty),
        .tx_full(tx_full), .rx_rdy_n(rx_rdy_n), .tx_rdy_n(tx_rdy_n)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    // reference model, computed from the requirements
    int rxq[$];
    int txq[$];
    int m_rxd = 0, m_txd = 0, m_cap = 1, m_rxs = 0, m_txs = 0;
    bit m_rxn = 1'b1, m_txn = 1'b1, m_pop_ok = 1'b0, m_push_ok = 1'b0;

    function automatic bit burst_mode(input logic [7:0] c);
        return c[0] && c[3];
    endfunction

    function automatic string pin_tag(input logic [7:0] c);
        if (!c[0]) return "R4";
        if (c[3]) return "R7";
        return "R5";
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            rxq.delete(); txq.delete();
            m_rxd = 0; m_txd = 0; m_rxn = 1'b1; m_txn = 1'b1;
        end else begin
            m_rxs = rxq.size();
            m_txs = txq.size();
            m_cap = cfg_word[0] ? 128 : 1;
            if (burst_mode(cfg_word)) begin
                if (m_rxs == 0) m_rxn = 1'b1;
                else if (m_rxs >= int'(rx_trig) || rx_timeout) m_rxn = 1'b0;
                m_txn = (m_txs >= m_cap);
            end else begin
                m_rxn = (m_rxs == 0);
                m_txn = (m_txs != 0);
            end
            if (rx_clr) rxq.delete();
            else begin
                m_pop_ok  = rx_pop && (m_rxs > 0);
                m_push_ok = rx_push && (m_rxs < m_cap || m_pop_ok);
                if (m_pop_ok) m_rxd = rxq.pop_front();
                if (m_push_ok) rxq.push_back(int'(rx_din));
            end
            if (tx_clr) txq.delete();
            else begin
                m_pop_ok  = tx_pop && (m_txs > 0);
                m_push_ok = tx_push && (m_txs < m_cap || m_pop_ok);
                if (m_pop_ok) m_txd = txq.pop_front();
                if (m_push_ok) txq.push_back(int'(tx_din));
            end
        end
    end

    // cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst && mon_on) begin
            chk("R1", "rx_count", int'(rx_count), rxq.size());
            chk("R1", "tx_count", int'(tx_count), txq.size());
            chk("R1", "rx_full", int'(rx_full), int'(rxq.size() >= (cfg_word[0] ? 128 : 1)));
            chk("R1", "tx_full", int'(tx_full), int'(txq.size() >= (cfg_word[0] ? 128 : 1)));
            chk("R2", "rx_empty", int'(rx_empty), int'(rxq.size() == 0));
            chk("R2", "tx_empty", int'(tx_empty), int'(txq.size() == 0));
            chk("R2", "rx_dout", int'(rx_dout), m_rxd);
            chk("R2", "tx_dout", int'(tx_dout), m_txd);
            chk(pin_tag(cfg_word), "rx_rdy_n", int'(rx_rdy_n), int'(m_rxn));
            chk(burst_mode(cfg_word) ? "R8" : pin_tag(cfg_word), "tx_rdy_n", int'(tx_rdy_n), int'(m_txn));
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic push_rx(input int n);
        for (int i = 0; i < n; i++) begin
            rx_push = 1'b1; rx_din = 8'($urandom);
            @(negedge clk);
        end
        rx_push = 1'b0;
    endtask

    task automatic pop_rx(input int n);
        for (int i = 0; i < n; i++) begin
            rx_pop = 1'b1;
            @(negedge clk);
        end
        rx_pop = 1'b0;
    endtask

    task automatic push_tx(input int n);
        for (int i = 0; i < n; i++) begin
            tx_push = 1'b1; tx_din = 8'($urandom);
            @(negedge clk);
        end
        tx_push = 1'b0;
    endtask

    task automatic clear_both();
        rx_clr = 1'b1; tx_clr = 1'b1;
        @(negedge clk);
        rx_clr = 1'b0; tx_clr = 1'b0;
        idle(1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'd20240611);
        repeat (3) @(negedge clk);
        // R10: reset state
        chk("R10", "rx_rdy_n", int'(rx_rdy_n), 1);
        chk("R10", "tx_rdy_n", int'(tx_rdy_n), 1);
        chk("R10", "rx_count", int'(rx_count), 0);
        chk("R10", "tx_empty", int'(tx_empty), 1);
        rst = 1'b0;
        mon_on = 1'b1;
        idle(2);

        // R9: stream mode, pin lags the count by one clock
        cfg_word = 8'h01;
        push_rx(1);
        chk("R9", "rx_count after push", int'(rx_count), 1);
        chk("R9", "rx_rdy_n still high", int'(rx_rdy_n), 1);
        idle(1);
        chk("R9", "rx_rdy_n low", int'(rx_rdy_n), 0);
        clear_both();

        // R1: fill past capacity
        push_tx(130);
        idle(1);
        chk("R1", "tx_count at capacity", int'(tx_count), 128);
        chk("R1", "tx_full", int'(tx_full), 1);
        // R3: simultaneous push and pop on a full queue
        tx_push = 1'b1; tx_pop = 1'b1; @(negedge clk); tx_push = 1'b0; tx_pop = 1'b0;
        chk("R3", "tx_count balanced", int'(tx_count), 128);
        clear_both();
        idle(1);
        chk("R11", "tx_rdy_n after clear", int'(tx_rdy_n), 0);
        // R2: pop from empty
        pop_rx(2);
        chk("R2", "rx_count after empty pop", int'(rx_count), 0);

        // R4: single-byte mode, burst bit ignored
        cfg_word = 8'h08;
        push_rx(3);
        idle(1);
        chk("R4", "rx_count single", int'(rx_count), 1);
        chk("R4", "rx_rdy_n single", int'(rx_rdy_n), 0);
        clear_both();

        // R6 R7: burst mode threshold and hysteresis
        cfg_word = 8'h09; rx_trig = 8'd4;
        push_rx(3); idle(1);
        chk("R6", "rx_rdy_n below trigger", int'(rx_rdy_n), 1);
        push_rx(1); idle(1);
        chk("R6", "rx_rdy_n at trigger", int'(rx_rdy_n), 0);
        pop_rx(3); idle(1);
        chk("R7", "rx_rdy_n held", int'(rx_rdy_n), 0);
        pop_rx(1); idle(1);
        chk("R7", "rx_rdy_n released", int'(rx_rdy_n), 1);
        // R6: timeout
        rx_trig = 8'd128;
        push_rx(2); idle(1);
        chk("R6", "rx_rdy_n before timeout", int'(rx_rdy_n), 1);
        rx_timeout = 1'b1; @(negedge clk); rx_timeout = 1'b0;
        chk("R6", "rx_rdy_n on timeout", int'(rx_rdy_n), 0);
        // R8: transmit full in burst mode
        push_tx(128); idle(1);
        chk("R8", "tx_rdy_n full", int'(tx_rdy_n), 1);
        // R11: clear returns pins to empty levels
        clear_both();
        chk("R11", "rx_rdy_n after clear", int'(rx_rdy_n), 1);
        chk("R11", "tx_rdy_n after clear", int'(tx_rdy_n), 0);

        // constrained random phases
        for (int seg = 0; seg < 16; seg++) begin
            int pp, qp;
            cfg_word = 8'($urandom) & 8'hF6;
            case (seg % 4)
                0: cfg_word[0] = 1'b0;
                1: cfg_word[0] = 1'b1;
                default: begin cfg_word[0] = 1'b1; cfg_word[3] = 1'b1; end
            endcase
            rx_trig = 8'(1 + ($urandom % 128));
            pp = (seg % 2) ? 85 : 20;
            qp = (seg % 2) ? 15 : 70;
            for (int c = 0; c < 450; c++) begin
                rx_push = ($urandom % 100) < pp;
                tx_push = ($urandom % 100) < pp;
                rx_pop  = ($urandom % 100) < qp;
                tx_pop  = ($urandom % 100) < qp;
                rx_din  = 8'($urandom);
                tx_din  = 8'($urandom);
                rx_timeout = ($urandom % 100) < 2;
                rx_clr  = ($urandom % 1000) < 3;
                tx_clr  = ($urandom % 1000) < 3;
                @(negedge clk);
            end
            rx_push = 0; tx_push = 0; rx_pop = 0; tx_pop = 0;
            rx_timeout = 0; rx_clr = 0; tx_clr = 0;
        end
        idle(2);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule